// File: doc/BRIEF.md
# Secure Key Slot Store

This block keeps cryptographic key material in 32 slots, each 256 bits wide and held as eight 32-bit words. A register bus reaches both the slots and two permission registers. Every bus access carries a flag that marks it as secure or non-secure. A separate combinational read port lets a crypto engine fetch one key word per cycle without going through the bus.

Two 32-bit masks decide who may touch which slot. The first mask lists the slots that a non-secure bus master may read or write. The second mask lists the slots that the engine port may read. Secure bus accesses always pass. Only secure bus accesses can reach the two mask registers.

A bus access that is refused has no effect on storage. A refused read returns zero, and the refusal is flagged on a one-cycle violation output. An engine read that is refused returns zero and raises a deny flag in the same cycle.

Top module: `key_slot_store`

## Requirements
- R1: After reset, the following hold:
  - The non-secure mask is 0x200000FF, so slots 0 to 7 and slot 29 are open to non-secure masters.
  - The engine mask is 0xFFFFFFFF.
  - Every slot word is zero.
  - `busRdata` is zero.
  - `busViolation` and `engDeny` are low.
- R2: A secure access can read or write any slot word. Word W of slot N sits at byte offset N*0x20 + W*4, and address bits 1:0 are ignored. Read data appears on `busRdata` one cycle after the request.
- R3: A non-secure access to a slot whose bit is set in the non-secure mask reads and writes exactly as a secure access does.
- R4: A non-secure read of a slot whose non-secure mask bit is clear does two things one cycle after the request: it returns zero on `busRdata`, and it raises `busViolation` for that one cycle.
- R5: A non-secure write to a slot whose non-secure mask bit is clear leaves the slot unchanged. It raises `busViolation` one cycle after the request.
- R6: A secure access reads or writes the non-secure mask at offset 0x400. A new value takes effect for the very next access.
- R7: A secure access reads or writes the engine mask at offset 0x404.
- R8: A non-secure access to offset 0x400 or 0x404 reads as zero, leaves the mask unchanged, and raises `busViolation` one cycle after the request.
- R9: Offsets 0x408 and above read as zero, ignore writes, and never raise `busViolation`.
- R10: While `engReq` is high, `engRdata` gives the addressed word in the same cycle if the slot's engine mask bit is set. If the bit is clear, `engRdata` is zero and `engDeny` is high in that cycle. `engDeny` is low whenever `engReq` is low.
- R11: `busRdata` holds its value in every cycle that follows a cycle with no bus read. `busViolation` is low after any secure access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | Bus access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSecure | input | 1 | Access carries the secure attribute |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the request |
| busViolation | output | 1 | One-cycle pulse for a refused bus access |
| engReq | input | 1 | Engine read request |
| engSlot | input | 5 | Engine slot index |
| engWord | input | 3 | Engine word index within the slot |
| engRdata | output | 32 | Engine read data, same cycle |
| engDeny | output | 1 | Engine read refused, same cycle |

## Verification
The hardest case to reach from the ports is a non-secure write that is silently dropped. The write changes nothing visible at the moment it happens. Its absence only shows up on a later secure readback of the same word, so the bench keeps a shadow copy of every slot and compares each later read against it. A refused engine read is similar: it needs a secure write that first clears engine mask bits. The random phase therefore reprograms both masks with secure writes in between slot traffic, so that permitted and refused accesses alternate on the same slots.

// File: rtl/kss_pkg.sv
package kss_pkg;

  typedef enum logic [1:0] {
    RD_ZERO    = 2'd0,
    RD_SLOT    = 2'd1,
    RD_NSMASK  = 2'd2,
    RD_ENGMASK = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic   slotWrEn;
    logic   nsMaskWrEn;
    logic   engMaskWrEn;
    logic   rdEn;
    rdSrc_e rdSrc;
    logic   violation;
  } kssStrobes_t;

endpackage

// File: rtl/kss_ctrl.sv
module kss_ctrl
  import kss_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 32,
  parameter int WORDS     = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic                 busSecure,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [NUM_SLOTS-1:0] nsMask,
  output kssStrobes_t          strobes
);
  localparam int BYTES     = DATA_W / 8;
  localparam int WORD_W    = $clog2(WORDS);
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int IDX_W     = SLOT_W + WORD_W;
  localparam int BYTE_W    = $clog2(BYTES);
  localparam int WA_W      = ADDR_W - BYTE_W;
  localparam int MASK_BASE = NUM_SLOTS * WORDS * BYTES;
  localparam logic [WA_W-1:0] NS_IDX  = WA_W'(MASK_BASE / BYTES);
  localparam logic [WA_W-1:0] ENG_IDX = WA_W'(MASK_BASE / BYTES + 1);

  logic [WA_W-1:0]   wordAddr;
  logic [SLOT_W-1:0] slotIdx;
  logic              inSlots;
  logic              slotOk;
  logic              unusedByteBits;

  assign wordAddr       = busAddr[ADDR_W-1:BYTE_W];
  assign slotIdx        = busAddr[IDX_W+BYTE_W-1:WORD_W+BYTE_W];
  assign inSlots        = wordAddr < NS_IDX;
  assign slotOk         = busSecure || nsMask[slotIdx];
  assign unusedByteBits = ^busAddr[BYTE_W-1:0];

  always_comb begin
    strobes       = '0;
    strobes.rdSrc = RD_ZERO;
    strobes.rdEn  = busValid && !busWrite;
    if (busValid) begin
      if (inSlots) begin
        if (!slotOk)       strobes.violation = 1'b1;
        else if (busWrite) strobes.slotWrEn  = 1'b1;
        else               strobes.rdSrc     = RD_SLOT;
      end else if (wordAddr == NS_IDX) begin
        if (!busSecure)    strobes.violation  = 1'b1;
        else if (busWrite) strobes.nsMaskWrEn = 1'b1;
        else               strobes.rdSrc      = RD_NSMASK;
      end else if (wordAddr == ENG_IDX) begin
        if (!busSecure)    strobes.violation   = 1'b1;
        else if (busWrite) strobes.engMaskWrEn = 1'b1;
        else               strobes.rdSrc       = RD_ENGMASK;
      end
    end
  end
endmodule

// File: rtl/kss_datapath.sv
module kss_datapath
  import kss_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int WORDS     = 8,
  parameter int DATA_W    = 32,
  parameter logic [NUM_SLOTS-1:0] NS_RESET  = 32'h2000_00FF,
  parameter logic [NUM_SLOTS-1:0] ENG_RESET = 32'hFFFF_FFFF
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  kssStrobes_t                              strobes,
  input  logic [$clog2(NUM_SLOTS*WORDS)-1:0]       wordIdx,
  input  logic [DATA_W-1:0]                        busWdata,
  output logic [DATA_W-1:0]                        busRdata,
  output logic                                     busViolation,
  output logic [NUM_SLOTS-1:0]                     nsMask,
  input  logic                                     engReq,
  input  logic [$clog2(NUM_SLOTS)-1:0]             engSlot,
  input  logic [$clog2(WORDS)-1:0]                 engWord,
  output logic [DATA_W-1:0]                        engRdata,
  output logic                                     engDeny
);
  localparam int DEPTH = NUM_SLOTS * WORDS;

  logic [DATA_W-1:0]    keyMem [DEPTH];
  logic [NUM_SLOTS-1:0] engMask;
  logic [DATA_W-1:0]    rdMux;

  always_comb begin
    unique case (strobes.rdSrc)
      RD_SLOT:    rdMux = keyMem[wordIdx];
      RD_NSMASK:  rdMux = DATA_W'(nsMask);
      RD_ENGMASK: rdMux = DATA_W'(engMask);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) keyMem[i] <= '0;
      nsMask       <= NS_RESET;
      engMask      <= ENG_RESET;
      busRdata     <= '0;
      busViolation <= 1'b0;
    end else begin
      if (strobes.slotWrEn)    keyMem[wordIdx] <= busWdata;
      if (strobes.nsMaskWrEn)  nsMask  <= busWdata[NUM_SLOTS-1:0];
      if (strobes.engMaskWrEn) engMask <= busWdata[NUM_SLOTS-1:0];
      if (strobes.rdEn)        busRdata <= rdMux;
      busViolation <= strobes.violation;
    end
  end

  assign engDeny  = engReq && !engMask[engSlot];
  assign engRdata = (engReq && engMask[engSlot]) ? keyMem[{engSlot, engWord}] : '0;
endmodule

// File: rtl/key_slot_store.sv
module key_slot_store
  import kss_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 32,
  parameter int WORDS     = 8,
  parameter int DATA_W    = 32,
  parameter logic [NUM_SLOTS-1:0] NS_RESET  = 32'h2000_00FF,
  parameter logic [NUM_SLOTS-1:0] ENG_RESET = 32'hFFFF_FFFF
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         busValid,
  input  logic                         busWrite,
  input  logic                         busSecure,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWdata,
  output logic [DATA_W-1:0]            busRdata,
  output logic                         busViolation,
  input  logic                         engReq,
  input  logic [$clog2(NUM_SLOTS)-1:0] engSlot,
  input  logic [$clog2(WORDS)-1:0]     engWord,
  output logic [DATA_W-1:0]            engRdata,
  output logic                         engDeny
);
  localparam int IDX_W  = $clog2(NUM_SLOTS * WORDS);
  localparam int BYTE_W = $clog2(DATA_W / 8);

  kssStrobes_t          strobes;
  logic [NUM_SLOTS-1:0] nsMask;
  logic [IDX_W-1:0]     wordIdx;

  assign wordIdx = busAddr[IDX_W+BYTE_W-1:BYTE_W];

  kss_ctrl #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS), .DATA_W(DATA_W)
  ) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busSecure(busSecure),
    .busAddr(busAddr), .nsMask(nsMask), .strobes(strobes)
  );

  kss_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS), .DATA_W(DATA_W),
    .NS_RESET(NS_RESET), .ENG_RESET(ENG_RESET)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wordIdx(wordIdx),
    .busWdata(busWdata), .busRdata(busRdata), .busViolation(busViolation),
    .nsMask(nsMask), .engReq(engReq), .engSlot(engSlot), .engWord(engWord),
    .engRdata(engRdata), .engDeny(engDeny)
  );
endmodule

// File: rtl/kss_checker.sv
module kss_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busValid,
  input logic              busWrite,
  input logic              busSecure,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              busViolation,
  input logic              engReq,
  input logic [DATA_W-1:0] engRdata,
  input logic              engDeny
);
  localparam logic [ADDR_W-1:0] TOP_REG = ADDR_W'(12'h408);

  // R4 R5 R8: a violation pulse always follows a non-secure request
  a_r4_violation_cause: assert property (@(posedge clk) disable iff (rst)
    busViolation |-> $past(busValid && !busSecure));

  // R4: a refused read returns zero
  a_r4_denied_read_zero: assert property (@(posedge clk) disable iff (rst)
    (busViolation && $past(!busWrite)) |-> busRdata == '0);

  // R11: secure accesses never raise a violation
  a_r11_secure_no_violation: assert property (@(posedge clk) disable iff (rst)
    (busValid && busSecure) |=> !busViolation);

  // R9: high offsets read zero and never raise a violation
  a_r9_high_read_zero: assert property (@(posedge clk) disable iff (rst)
    (busValid && !busWrite && busAddr >= TOP_REG) |=> (busRdata == '0 && !busViolation));

  // R11: read data holds when no read was requested
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(busValid && !busWrite) |=> $stable(busRdata));

  // R10: deny only with a request, and denied data is zero
  a_r10_deny_needs_req: assert property (@(posedge clk) disable iff (rst)
    engDeny |-> engReq);
  a_r10_deny_zero: assert property (@(posedge clk) disable iff (rst)
    engDeny |-> engRdata == '0);
endmodule

bind key_slot_store kss_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_kss_checker (
  .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
  .busSecure(busSecure), .busAddr(busAddr), .busRdata(busRdata),
  .busViolation(busViolation), .engReq(engReq), .engRdata(engRdata),
  .engDeny(engDeny)
);

// File: tb/tb_key_slot_store.sv
module tb_key_slot_store;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0, busWrite = 1'b0, busSecure = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busViolation;
  logic        engReq = 1'b0;
  logic [4:0]  engSlot = '0;
  logic [2:0]  engWord = '0;
  logic [31:0] engRdata;
  logic        engDeny;

  logic [31:0] refMem [256];
  logic [31:0] refNs, refEng;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_slot_store dut (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite),
    .busSecure(busSecure), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busViolation(busViolation), .engReq(engReq),
    .engSlot(engSlot), .engWord(engWord), .engRdata(engRdata), .engDeny(engDeny)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(bit sec, logic [11:0] a);
    int idx = int'(a[11:2]);
    if (idx < 256) return (sec || refNs[idx/8]) ? refMem[idx] : 32'h0;
    if (idx == 256) return sec ? refNs : 32'h0;
    if (idx == 257) return sec ? refEng : 32'h0;
    return 32'h0;
  endfunction

  function automatic bit expViol(bit sec, logic [11:0] a);
    int idx = int'(a[11:2]);
    if (idx < 256) return !sec && !refNs[idx/8];
    if (idx == 256 || idx == 257) return !sec;
    return 1'b0;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic busOp(bit wr, bit sec, logic [11:0] a, logic [31:0] d, string req);
    logic [31:0] prevRd = busRdata;
    int idx = int'(a[11:2]);
    busValid = 1'b1; busWrite = wr; busSecure = sec; busAddr = a; busWdata = d;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check(req, 32'(busViolation), 32'(expViol(sec, a)));
    if (!wr) check(req, busRdata, expRead(sec, a));
    else begin
      check({req, " R11 hold"}, busRdata, prevRd);
      if (idx < 256 && (sec || refNs[idx/8])) refMem[idx] = d;
      else if (idx == 256 && sec) refNs = d;
      else if (idx == 257 && sec) refEng = d;
    end
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic engOp(logic [4:0] s, logic [2:0] w, string req);
    engReq = 1'b1; engSlot = s; engWord = w;
    #1;
    check(req, engRdata, refEng[s] ? refMem[{s, w}] : 32'h0);
    check(req, 32'(engDeny), 32'(!refEng[s]));
    engReq = 1'b0;
    #1;
    check({req, " idle"}, 32'(engDeny), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) refMem[i] = '0;
    refNs = 32'h2000_00FF; refEng = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 rdata", busRdata, 32'h0);
    check("R1 violation", 32'(busViolation), 32'h0);
    check("R1 deny", 32'(engDeny), 32'h0);
    busOp(1'b0, 1'b1, 12'h400, 0, "R1 ns mask reset");
    busOp(1'b0, 1'b1, 12'h404, 0, "R1 eng mask reset");
    busOp(1'b0, 1'b1, 12'h3FC, 0, "R1 slot zero");

    // R2: secure write/read anywhere, byte bits ignored
    busOp(1'b1, 1'b1, 12'h104, 32'hDEAD_BEEF, "R2 secure write slot 8");
    busOp(1'b0, 1'b1, 12'h107, 0, "R2 secure read slot 8");
    // R4 / R5: denied non-secure access to slot 8
    busOp(1'b0, 1'b0, 12'h104, 0, "R4 ns read denied");
    busOp(1'b1, 1'b0, 12'h104, 32'h1111_2222, "R5 ns write denied");
    busOp(1'b0, 1'b1, 12'h104, 0, "R5 slot unchanged");
    // R3: non-secure to open slots 0 and 29
    busOp(1'b1, 1'b0, 12'h3A0, 32'hCAFE_0029, "R3 ns write slot 29");
    busOp(1'b0, 1'b0, 12'h3A0, 0, "R3 ns read slot 29");
    busOp(1'b1, 1'b0, 12'h01C, 32'h0000_A5A5, "R3 ns write slot 0");
    busOp(1'b0, 1'b1, 12'h01C, 0, "R3 secure readback slot 0");
    // R8: non-secure access to mask registers
    busOp(1'b0, 1'b0, 12'h400, 0, "R8 ns read mask");
    busOp(1'b1, 1'b0, 12'h400, 32'hFFFF_FFFF, "R8 ns write mask");
    busOp(1'b1, 1'b0, 12'h404, 32'h0, "R8 ns write eng mask");
    busOp(1'b0, 1'b1, 12'h400, 0, "R8 mask unchanged");
    // R6: opening slot 8 takes effect on the next access
    busOp(1'b1, 1'b1, 12'h400, 32'h0000_0100, "R6 write ns mask");
    busOp(1'b0, 1'b0, 12'h104, 0, "R6 ns read now allowed");
    busOp(1'b0, 1'b0, 12'h000, 0, "R6 slot 0 now denied");
    // R9: high offsets
    busOp(1'b1, 1'b1, 12'h408, 32'h1234_5678, "R9 write high");
    busOp(1'b0, 1'b1, 12'h408, 0, "R9 read 0x408");
    busOp(1'b0, 1'b0, 12'hFFC, 0, "R9 read 0xFFC");
    // R7 / R10: engine masking
    engOp(5'd8, 3'd1, "R10 engine allowed");
    busOp(1'b1, 1'b1, 12'h404, 32'hFFFF_FEFF, "R7 write eng mask");
    busOp(1'b0, 1'b1, 12'h404, 0, "R7 read eng mask");
    engOp(5'd8, 3'd1, "R10 engine denied");
    engOp(5'd29, 3'd0, "R10 engine slot 29");

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int r = int'($urandom % 100);
      logic [11:0] a;
      if (r < 72)      a = {2'b00, 5'($urandom), 3'($urandom), 2'($urandom)};
      else if (r < 82) a = 12'h400;
      else if (r < 90) a = 12'h404;
      else             a = 12'h408 + 12'(4 * ($urandom % 766));
      busOp(1'($urandom), 1'($urandom), a, $urandom, "R2 R3 R4 R5 R6 R7 R8 R9 random bus");
      if (($urandom % 3) == 0) engOp(5'($urandom), 3'($urandom), "R10 random engine");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule